// File: doc/BRIEF.md
# Serial Byte Memory Slave

This block is a serial-peripheral slave in front of a small byte-wide RAM. A host selects the block by pulling chip select low and clocks it in SPI mode 0 or mode 3. The first byte of every selection is a command. Reads and writes take a 16-bit address field, then stream data bytes in either direction while the address advances on its own. Writes finish as each byte arrives, so the host never waits for a busy flag. A write-enable latch, set and cleared by dedicated commands, guards the array against stray writes.

The serial pins are brought into the system clock domain through a synchronizer and edge detector. All protocol logic then runs on the system clock, which must be at least eight times faster than the serial clock. The array size is set by `ADDR_W`. The default of 11 gives 2,048 bytes and keeps elaboration light. A full-size instance sets `ADDR_W` to 13, giving 8,192 bytes with the address wrapping at 0x1FFF.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the output enable `spi_so_oe` is low and the write-enable latch is clear, so a status read returns 0x00.
- R2: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns a status byte whose bit 1 is the latch and whose other bits, including the busy bit 0, read as 0.
- R3: Command 0x02, followed by a high and then a low address byte and then data bytes, stores the data when the latch is set. Command 0x03 with the same address returns it MSB first. Both operations work in mode 0 (clock idle low) and in mode 3 (clock idle high), with input sampled on rising and output changed on falling clock edges.
- R4: Only the low `ADDR_W` bits of the 16-bit address field are used; the upper bits have no effect on which byte is accessed.
- R5: During a read or write burst the address advances by one per byte and wraps from 2^ADDR_W-1 to 0.
- R6: A write data byte received while the latch is clear leaves the array unchanged.
- R7: When chip select rises after a write (0x02) or write-status (0x01) command, the latch is cleared. The data byte of 0x01 is discarded.
- R8: A data byte cut short by chip select rising before its 8th bit is not written.
- R9: Only the first byte after chip select falls is decoded as a command. Later bytes in the same selection never act as commands, and an unknown first byte makes the rest of the selection inert.
- R10: `spi_so_oe` is high only during the data phase of a read or status read, and goes low within 5 system clocks of chip select rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data from the host |
| spi_so | output | 1 | Serial data to the host |
| spi_so_oe | output | 1 | Drive enable for `spi_so`; the pad is released when low |

## Verification
The bench targets the address wrap at the top of the array: a design that carried into a dropped bit, or that never wrapped, would read back the wrong bytes after the wrap point. It sends addresses with the upper field bits set, which a design that did not mask them would alias to the wrong location. It aborts a byte after five bits, which a design that stored partial bytes would leave in the array. It also issues a second command inside one selection, which a decoder that re-armed per byte would obey and so change the latch. It runs reads in the opposite clock polarity from the writes, which catches output that was loaded one edge early or late in mode 3.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
   localparam logic [7:0] CMD_NONE  = 8'h00;
   localparam logic [7:0] CMD_WRSR  = 8'h01;
   localparam logic [7:0] CMD_WRITE = 8'h02;
   localparam logic [7:0] CMD_READ  = 8'h03;
   localparam logic [7:0] CMD_WRDI  = 8'h04;
   localparam logic [7:0] CMD_RDSR  = 8'h05;
   localparam logic [7:0] CMD_WREN  = 8'h06;

   typedef enum logic [1:0] {
      PH_CMD  = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_MUTE = 2'd3
   } phase_e;
endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      if (STAGES < 1) begin : g_bad
         $error("spi_mem_sync: STAGES must be at least 1");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[i] <= RST_VAL;
            else if (i == 0) stg[i] <= d;
            else             stg[i] <= stg[(i == 0) ? 0 : i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              si_s,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              so,
   output logic              so_oe
);
   localparam int               HI_W     = ADDR_W - 8;
   localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

   logic              sck_d, sel_d;
   logic              sel, sck_rise, sck_fall, sel_end;
   phase_e            phase;
   logic [7:0]        cmd_q;
   logic [2:0]        bit_cnt;
   logic [6:0]        rx_sr;
   logic [7:0]        rx_byte;
   logic              byte_done, addr_lo_next;
   logic [ADDR_W-1:0] addr;
   logic              wel;
   logic [7:0]        tx_sr;
   logic              tx_on;
   logic              is_rd_cmd;
   logic [7:0]        status_byte;

   assign sel         = ~cs_n_s;
   assign sck_rise    = sel &  sck_s & ~sck_d;
   assign sck_fall    = sel & ~sck_s &  sck_d;
   assign sel_end     = sel_d & ~sel;
   assign rx_byte     = {rx_sr, si_s};
   assign byte_done   = sck_rise && (bit_cnt == 3'd7);
   assign is_rd_cmd   = (cmd_q == CMD_READ) || (cmd_q == CMD_RDSR);
   assign status_byte = {6'b0, wel, 1'b0};

   assign mem_we    = byte_done && (phase == PH_DATA) && (cmd_q == CMD_WRITE) && wel;
   assign mem_addr  = addr;
   assign mem_wdata = rx_byte;
   assign so        = tx_sr[7];
   assign so_oe     = tx_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d        <= 1'b0;
         sel_d        <= 1'b0;
         phase        <= PH_CMD;
         cmd_q        <= CMD_NONE;
         bit_cnt      <= '0;
         rx_sr        <= '0;
         addr_lo_next <= 1'b0;
         addr         <= '0;
         wel          <= 1'b0;
         tx_sr        <= '0;
         tx_on        <= 1'b0;
      end else begin
         sck_d <= sck_s;
         sel_d <= sel;
         if (!sel) begin
            phase        <= PH_CMD;
            bit_cnt      <= '0;
            addr_lo_next <= 1'b0;
            tx_on        <= 1'b0;
            if (sel_end) begin
               if ((cmd_q == CMD_WRITE) || (cmd_q == CMD_WRSR)) wel <= 1'b0;
               cmd_q <= CMD_NONE;
            end
         end else begin
            if (sck_rise) begin
               rx_sr   <= rx_byte[6:0];
               bit_cnt <= bit_cnt + 3'd1;
            end
            if (byte_done) begin
               unique case (phase)
                  PH_CMD: begin
                     cmd_q <= rx_byte;
                     case (rx_byte)
                        CMD_WREN:            begin wel <= 1'b1; phase <= PH_MUTE; end
                        CMD_WRDI:            begin wel <= 1'b0; phase <= PH_MUTE; end
                        CMD_READ, CMD_WRITE: phase <= PH_ADDR;
                        CMD_RDSR, CMD_WRSR:  phase <= PH_DATA;
                        default:             phase <= PH_MUTE;
                     endcase
                  end
                  PH_ADDR: begin
                     if (!addr_lo_next) begin
                        addr[ADDR_W-1:8] <= rx_byte[HI_W-1:0];
                        addr_lo_next     <= 1'b1;
                     end else begin
                        addr[7:0] <= rx_byte;
                        phase     <= PH_DATA;
                     end
                  end
                  PH_DATA: if (cmd_q == CMD_WRITE) addr <= addr + 1'b1;
                  PH_MUTE: ;
               endcase
            end
            if (sck_fall && (phase == PH_DATA) && is_rd_cmd) begin
               if (bit_cnt == 3'd0) begin
                  tx_on <= 1'b1;
                  tx_sr <= (cmd_q == CMD_RDSR) ? status_byte : mem_rdata;
                  if (cmd_q == CMD_READ) addr <= addr + 1'b1;
               end else begin
                  tx_sr <= {tx_sr[6:0], 1'b0};
               end
            end
         end
      end
   end

   generate
      if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_aw
         $error("spi_mem_ctrl: ADDR_W must lie in 9..16");
      end
   endgenerate

   AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      so_oe |-> sel_d) else $error("so_oe without chip select"); // R10
   AST_WE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> wel) else $error("array write with latch clear"); // R6
   AST_WEL_DROP_END: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_end && (cmd_q == CMD_WRITE || cmd_q == CMD_WRSR)) |=> !wel) else $error("latch kept after write"); // R7
   AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && phase == PH_CMD && rx_byte == CMD_WREN) |=> wel) else $error("enable command lost"); // R2
   AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && addr == ADDR_TOP) |=> (addr == '0)) else $error("address did not wrap"); // R5
   AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && phase != PH_CMD) |=> (phase != PH_CMD)) else $error("decoder re-armed mid selection"); // R9
   AST_WE_FULL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (sel && sel_d)) else $error("write outside selection"); // R8
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
   parameter int ADDR_W      = 11,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic spi_sck,
   input  logic spi_cs_n,
   input  logic spi_si,
   output logic spi_so,
   output logic spi_so_oe
);
   logic              sck_s, cs_n_s, si_s;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata, mem_rdata;

   generate
      if (SYNC_STAGES > 0) begin : g_sync
         spi_mem_sync #(
            .W       (3),
            .STAGES  (SYNC_STAGES),
            .RST_VAL (3'b010)
         ) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     ({spi_si, spi_cs_n, spi_sck}),
            .q     ({si_s, cs_n_s, sck_s})
         );
      end else begin : g_direct
         assign {si_s, cs_n_s, sck_s} = {spi_si, spi_cs_n, spi_sck};
      end
   endgenerate

   spi_mem_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .sck_s     (sck_s),
      .cs_n_s    (cs_n_s),
      .si_s      (si_s),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .so        (spi_so),
      .so_oe     (spi_so_oe)
   );

   spi_mem_array #(.ADDR_W(ADDR_W)) u_array (
      .clk   (clk),
      .we    (mem_we),
      .addr  (mem_addr),
      .wdata (mem_wdata),
      .rdata (mem_rdata)
   );
endmodule

// File: tb/spi_mem_slave_tb.sv
`timescale 1ns/1ps
module spi_mem_slave_tb;
   localparam int ADDR_W = 11;
   localparam int HALF   = 6;
   localparam logic [15:0] AMASK = 16'((1 << ADDR_W) - 1);

   // vector: {address field, data, read-back mode3, write mode3}
   localparam logic [25:0] VEC [6] = '{
      {16'h0005, 8'hA5, 1'b0, 1'b0},
      {16'hF805, 8'h3C, 1'b1, 1'b0},
      {16'h0123, 8'h81, 1'b0, 1'b1},
      {16'h7BFF, 8'h7E, 1'b1, 1'b1},
      {16'h0400, 8'h00, 1'b1, 1'b0},
      {16'hFFFF, 8'hFF, 1'b0, 1'b1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_si = 1'b0;
   logic spi_so, spi_so_oe;
   logic cur_m3 = 1'b0;
   int   checks = 0, fails = 0;

   always #4 clk = ~clk;

   spi_mem_slave #(.ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
      .spi_si(spi_si), .spi_so(spi_so), .spi_so_oe(spi_so_oe)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic sel_on(input logic m3);
      cur_m3 = m3;
      @(negedge clk) spi_sck = m3;
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic sel_off();
      @(negedge clk) if (!cur_m3) spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (2*HALF) @(negedge clk);
   endtask

   task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
      rx = '0;
      for (int i = 7; i > 7 - nbits; i--) begin
         @(negedge clk);
         spi_sck = 1'b0;
         spi_si  = tx[i];
         repeat (HALF) @(negedge clk);
         rx[i]   = spi_so_oe ? spi_so : 1'b0;
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
      end
   endtask

   task automatic cmd_only(input logic [7:0] c);
      logic [7:0] r;
      sel_on(1'b0); xfer(c, 8, r); sel_off();
   endtask

   task automatic status(input logic m3, output logic [7:0] s);
      logic [7:0] r;
      sel_on(m3); xfer(8'h05, 8, r); xfer(8'h00, 8, s); sel_off();
   endtask

   task automatic wr1(input logic m3, input logic [15:0] a, input logic [7:0] d);
      logic [7:0] r;
      sel_on(m3); xfer(8'h02, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
      xfer(d, 8, r); sel_off();
   endtask

   task automatic rd1(input logic m3, input logic [15:0] a, output logic [7:0] d);
      logic [7:0] r;
      sel_on(m3); xfer(8'h03, 8, r); xfer(a[15:8], 8, r); xfer(a[7:0], 8, r);
      xfer(8'h00, 8, d); sel_off();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] s, d, r;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R1 reset state
      chk("R1 oe after reset", {7'b0, spi_so_oe}, 8'h00);
      status(1'b0, s); chk("R1 status after reset", s, 8'h00);

      // R2 latch commands and status bit 1
      cmd_only(8'h06); status(1'b1, s); chk("R2 status after enable", s, 8'h02);
      cmd_only(8'h04); status(1'b0, s); chk("R2 status after disable", s, 8'h00);

      // vector table: R3 both modes, R4 upper address bits ignored, R7 latch drop
      foreach (VEC[i]) begin
         cmd_only(8'h06);
         wr1(VEC[i][0], VEC[i][25:10], VEC[i][9:2]);
         status(1'b0, s); chk("R7 latch after write", s, 8'h00);
         rd1(VEC[i][1], VEC[i][25:10] & AMASK, d);
         chk("R3 R4 read back", d, VEC[i][9:2]);
      end

      // R6 write with latch clear
      cmd_only(8'h06); wr1(1'b0, 16'h0010, 8'h11);
      wr1(1'b0, 16'h0010, 8'hEE);
      rd1(1'b0, 16'h0010, d); chk("R6 write without enable", d, 8'h11);

      // R5 burst write and read across the top of the array
      cmd_only(8'h06);
      sel_on(1'b0); xfer(8'h02, 8, r); xfer(8'h07, 8, r); xfer(8'hFE, 8, r);
      for (int k = 0; k < 4; k++) xfer(8'hA0 + 8'(k), 8, r);
      sel_off();
      rd1(1'b1, 16'h0000, d); chk("R5 wrap write lands at 0", d, 8'hA2);
      sel_on(1'b1); xfer(8'h03, 8, r); xfer(8'h07, 8, r); xfer(8'hFE, 8, r);
      for (int k = 0; k < 4; k++) begin
         xfer(8'h00, 8, d); chk("R5 burst read", d, 8'hA0 + 8'(k));
      end
      chk("R10 oe during read data", {7'b0, spi_so_oe}, 8'h01);
      @(negedge clk) spi_cs_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10 oe after select rise", {7'b0, spi_so_oe}, 8'h00);
      repeat (HALF) @(negedge clk);

      // R8 partial byte discarded
      cmd_only(8'h06); wr1(1'b0, 16'h0021, 8'h44);
      cmd_only(8'h06);
      sel_on(1'b0); xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h20, 8, r);
      xfer(8'h33, 8, r); xfer(8'hFF, 5, r); sel_off();
      rd1(1'b0, 16'h0020, d); chk("R8 full byte kept", d, 8'h33);
      rd1(1'b0, 16'h0021, d); chk("R8 partial byte dropped", d, 8'h44);

      // R7 write-status clears latch
      cmd_only(8'h06);
      sel_on(1'b0); xfer(8'h01, 8, r); xfer(8'hFF, 8, r); sel_off();
      status(1'b0, s); chk("R7 latch after write status", s, 8'h00);

      // R9 one command per selection
      sel_on(1'b0); xfer(8'h04, 8, r); xfer(8'h06, 8, r); sel_off();
      status(1'b0, s); chk("R9 second command ignored", s, 8'h00);
      sel_on(1'b0); xfer(8'hAB, 8, r); xfer(8'h06, 8, r); sel_off();
      status(1'b0, s); chk("R9 unknown command mutes", s, 8'h00);
      sel_on(1'b1); xfer(8'h06, 8, r); xfer(8'h04, 8, r); sel_off();
      status(1'b0, s); chk("R9 disable after enable ignored", s, 8'h02);

      // R10 no drive during command and address phases
      sel_on(1'b0); xfer(8'h03, 8, r); xfer(8'h00, 8, r);
      chk("R10 oe in address phase", {7'b0, spi_so_oe}, 8'h00);
      xfer(8'h10, 8, r); sel_off();

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule